// File: doc/BRIEF.md
# Protected Page Translation Cache

This block is a small, fully associative cache of page translations. Every cycle it can take a 32-bit virtual address, together with an access kind (read or write), the current privilege mode and the current process tag. In the same cycle it reports a hit or a miss, the 30-bit physical address and a protection-fault flag. Pages are 4 KB. Every stored translation carries read, write and kernel-only rights. Because each translation is also tagged with its process, a process switch does not have to empty the cache.

Hits that do not fault mark the matching entry as recently used. A write hit also marks the entry as modified, and that state is reported on later hits. After a miss, an external table walker installs the missing translation through the fill port. The replacement choice uses the recently-used marks. Two flush controls are provided: one invalidates every entry, the other invalidates only the entries of a single process.

Top module: `xlate_cache`

## Requirements
- R1: On a hit, `lk_pa` equals the stored 18-bit physical page number in bits 29:12 and `lk_va[11:0]` in bits 11:0. The virtual page number is `lk_va[31:12]`. On a miss, `lk_pa` is zero.
- R2: `lk_hit` is 1 only when some valid entry holds both the virtual page number and `cur_pid`. A translation stored under another process tag does not hit.
- R3: At most one entry matches any lookup. A fill whose page number and tag are already present rewrites that entry, and the rewrite clears its modified mark.
- R4: A hit faults (`lk_fault`=1) when `lk_wr`=1 and the entry lacks write permission, or when `lk_wr`=0 and the entry lacks read permission.
- R5: A hit with `lk_user`=1 on a kernel-only entry faults, and a kernel-mode access to the same entry does not fault on that account. `lk_fault` is never 1 without `lk_hit`.
- R6: A non-faulting write hit sets the entry's modified mark from the next clock edge on. `lk_dirty` shows that mark on later hits. A faulting write leaves the mark clear, and a fill installs an entry with the mark clear.
- R7: A fill goes to the lowest-numbered invalid entry when one exists.
- R8: With every entry valid, a fill goes to the lowest-numbered entry whose used mark is clear. If every used mark is set, all of them are cleared and entry 0 is replaced. A non-faulting hit sets the used mark, and a fill leaves the used mark clear.
- R9: `flush_all` invalidates every entry in one cycle. A fill in the same cycle as any flush is dropped.
- R10: `flush_pid_en` invalidates exactly the entries whose tag equals `flush_pid`. Entries of other processes keep hitting.
- R11: After reset, no entry is valid.
- R12: With `lk_en`=0, `lk_hit`, `lk_fault` and `lk_dirty` are 0, and no used or modified mark changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_wr | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| cur_pid | input | 8 | Current process tag |
| lk_hit | output | 1 | Translation found |
| lk_fault | output | 1 | Rights violation on a hit |
| lk_pa | output | 30 | Physical address |
| lk_dirty | output | 1 | Modified mark of the hit entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_pid | input | 8 | Process tag to install |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_kern | input | 1 | Page is kernel-only |
| flush_all | input | 1 | Invalidate all entries |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | 8 | Process tag to invalidate |

## Verification
On every cycle the assertions check that no more than one entry matches, that a fault only comes with a hit, that an idle lookup port shows no hit, that each flush empties the entries it targets, that a fill lands in a valid entry, and that a clean write hit leaves the modified mark set. Only the bench's scenarios can show the actual address and rights results for given stored translations, the separation between process tags, and which entry the replacement picks. The replacement picks are made visible by which translations still hit after a sequence of fills and used marks.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic kern;
  } xc_perm_t;

  // Rights check for one access against one stored entry.
  function automatic logic perm_violation(xc_perm_t p, logic is_wr, logic is_user);
    logic bad_kind;
    bad_kind = is_wr ? !p.wr : !p.rd;
    return bad_kind || (is_user && p.kern);
  endfunction

endpackage

// File: rtl/xc_pick.sv
module xc_pick #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  // Lowest set bit wins.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/xc_entry.sv
module xc_entry
  import xc_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PID_W-1:0] fill_pid,
  input  xc_perm_t         fill_perm,
  input  logic             fill_sel,
  input  logic             fl_all,
  input  logic             fl_pid_en,
  input  logic [PID_W-1:0] fl_pid,
  input  logic             set_use,
  input  logic             clr_use,
  input  logic             set_dirty,
  output logic             lk_match,
  output logic             fill_match,
  output logic             flush_match,
  output logic             valid,
  output logic             used,
  output logic             dirty,
  output logic [PPN_W-1:0] ppn,
  output xc_perm_t         perm
);
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;

  assign lk_match    = valid && (vpn_q == lk_vpn) && (pid_q == lk_pid);
  assign fill_match  = valid && (vpn_q == fill_vpn) && (pid_q == fill_pid);
  assign flush_match = valid && (pid_q == fl_pid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      used  <= 1'b0;
      dirty <= 1'b0;
      vpn_q <= '0;
      pid_q <= '0;
      ppn   <= '0;
      perm  <= '0;
    end else if (fl_all || (fl_pid_en && flush_match)) begin
      valid <= 1'b0;
      used  <= 1'b0;
      dirty <= 1'b0;
    end else if (fill_sel) begin
      valid <= 1'b1;
      used  <= 1'b0;
      dirty <= 1'b0;
      vpn_q <= fill_vpn;
      pid_q <= fill_pid;
      ppn   <= fill_ppn;
      perm  <= fill_perm;
    end else begin
      used  <= (used && !clr_use) || set_use;
      dirty <= dirty || set_dirty;
    end
  end

  a_r11_flush_clears_marks: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (!valid && !used && !dirty));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xc_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int PG_W    = 12,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 32,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int PPN_W  = PA_W - PG_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_wr,
  input  logic             lk_user,
  input  logic [PID_W-1:0] cur_pid,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_kern,
  input  logic             flush_all,
  input  logic             flush_pid_en,
  input  logic [PID_W-1:0] flush_pid
);
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match_vec, dupl_vec, flmatch_vec;
  logic [ENTRIES-1:0] valid_vec, used_vec, dirty_vec;
  logic [ENTRIES-1:0] set_use_vec, set_dirty_vec, fill_sel_vec;
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];
  xc_perm_t           perm_arr [ENTRIES];

  logic               any_match, upd_ok, flush_any, fill_go, clr_use;
  logic               hit_found, dup_found, inv_found, clr_found, all_used;
  logic [IDX_W-1:0]   hit_idx, dup_idx, inv_idx, clr_idx, victim;
  xc_perm_t           fill_perm, hit_perm;

  assign lk_vpn    = lk_va[VA_W-1:PG_W];
  assign fill_perm = '{rd: fill_rd, wr: fill_wr, kern: fill_kern};
  assign flush_any = flush_all || flush_pid_en;

  // Lookup side
  xc_pick #(.N(ENTRIES)) u_hit_pick (.vec(match_vec), .found(hit_found), .idx(hit_idx));

  assign any_match = lk_en && hit_found;
  assign hit_perm  = perm_arr[hit_idx];
  assign lk_hit    = any_match;
  assign lk_fault  = any_match && perm_violation(hit_perm, lk_wr, lk_user);
  assign lk_pa     = any_match ? {ppn_arr[hit_idx], lk_va[PG_W-1:0]} : '0;
  assign lk_dirty  = any_match && dirty_vec[hit_idx];
  assign upd_ok    = any_match && !lk_fault && !flush_any;

  // Fill side: rewrite a duplicate, else first hole, else first unused
  xc_pick #(.N(ENTRIES)) u_dup_pick (.vec(dupl_vec),   .found(dup_found), .idx(dup_idx));
  xc_pick #(.N(ENTRIES)) u_inv_pick (.vec(~valid_vec), .found(inv_found), .idx(inv_idx));
  xc_pick #(.N(ENTRIES)) u_clr_pick (.vec(~used_vec),  .found(clr_found), .idx(clr_idx));

  assign all_used = !clr_found;
  assign fill_go  = fill_en && !flush_any;
  assign clr_use  = fill_go && !dup_found && !inv_found && all_used;

  always_comb begin
    if (dup_found)      victim = dup_idx;
    else if (inv_found) victim = inv_idx;
    else if (clr_found) victim = clr_idx;
    else                victim = '0;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign set_use_vec[g]   = upd_ok && (hit_idx == IDX_W'(g));
    assign set_dirty_vec[g] = upd_ok && lk_wr && (hit_idx == IDX_W'(g));
    assign fill_sel_vec[g]  = fill_go && (victim == IDX_W'(g));

    xc_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .lk_vpn      (lk_vpn),
      .lk_pid      (cur_pid),
      .fill_vpn    (fill_vpn),
      .fill_ppn    (fill_ppn),
      .fill_pid    (fill_pid),
      .fill_perm   (fill_perm),
      .fill_sel    (fill_sel_vec[g]),
      .fl_all      (flush_all),
      .fl_pid_en   (flush_pid_en),
      .fl_pid      (flush_pid),
      .set_use     (set_use_vec[g]),
      .clr_use     (clr_use),
      .set_dirty   (set_dirty_vec[g]),
      .lk_match    (match_vec[g]),
      .fill_match  (dupl_vec[g]),
      .flush_match (flmatch_vec[g]),
      .valid       (valid_vec[g]),
      .used        (used_vec[g]),
      .dirty       (dirty_vec[g]),
      .ppn         (ppn_arr[g]),
      .perm        (perm_arr[g])
    );
  end

  // Assertions
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  a_r12_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (!lk_hit && !lk_fault && !lk_dirty));

  a_r9_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  a_r10_flush_pid_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pid_en && !flush_all) |=> ((valid_vec & $past(flmatch_vec)) == '0));

  a_r8_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid_vec[$past(victim)]);

  a_r6_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_dirty_vec && !fill_en) |=> dirty_vec[$past(hit_idx)]);
endmodule

// File: tb/xlate_cache_bench.sv
`timescale 1ns/1ps
module xlate_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0, lk_wr = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  cur_pid = '0;
  logic        lk_hit, lk_fault, lk_dirty;
  logic [29:0] lk_pa;
  logic        fill_en = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_kern = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic [7:0]  fill_pid = '0;
  logic        flush_all = 1'b0, flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;

  int checks = 0;
  int errors = 0;
  logic        r_hit, r_fault, r_dirty;
  logic [29:0] r_pa;

  always #2 clk = ~clk;

  xlate_cache u_xlate_cache (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_wr(lk_wr),
    .lk_user(lk_user), .cur_pid(cur_pid), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_pa(lk_pa), .lk_dirty(lk_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_pid(fill_pid), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .fill_kern(fill_kern), .flush_all(flush_all), .flush_pid_en(flush_pid_en),
    .flush_pid(flush_pid)
  );

  // {va[73:42], wr[41], user[40], pid[39:32], hit[31], fault[30], pa[29:0]}
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 30'h00A01ABC},
    {32'h00010ABC, 1'b0, 1'b1, 8'd2, 1'b1, 1'b0, 30'h00B02ABC},
    {32'h00010ABC, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0, 30'h00000000},
    {32'h00011FFF, 1'b1, 1'b1, 8'd1, 1'b1, 1'b1, 30'h3FFFFFFF},
    {32'h00011000, 1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 30'h3FFFF000},
    {32'hFFFFF123, 1'b0, 1'b1, 8'd1, 1'b1, 1'b1, 30'h12345123},
    {32'hFFFFF123, 1'b1, 1'b0, 8'd1, 1'b1, 1'b0, 30'h12345123},
    {32'h00020004, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 30'h00005004},
    {32'h00020004, 1'b1, 1'b1, 8'd1, 1'b1, 1'b0, 30'h00005004},
    {32'h00030000, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 30'h00000000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic user,
                      input logic [7:0] pid, input logic en);
    @(negedge clk);
    lk_en = en; lk_va = va; lk_wr = wr; lk_user = user; cur_pid = pid;
    #1;
    r_hit = lk_hit; r_fault = lk_fault; r_pa = lk_pa; r_dirty = lk_dirty;
    @(posedge clk);
    #1 lk_en = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn, input logic [7:0] pid,
                      input logic rd, input logic wr, input logic kern);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_pid = pid;
    fill_rd = rd; fill_wr = wr; fill_kern = kern;
    @(posedge clk);
    #1 fill_en = 1'b0;
  endtask

  task automatic do_flush(input logic all, input logic [7:0] pid);
    @(negedge clk);
    flush_all = all; flush_pid_en = !all; flush_pid = pid;
    @(posedge clk);
    #1 begin flush_all = 1'b0; flush_pid_en = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: empty after reset
    look(32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R11 hit after reset", r_hit, 0);
    chk("R1 pa on miss", r_pa, 0);

    fill(20'h00010, 18'h00A01, 8'd1, 1'b1, 1'b1, 1'b0);
    fill(20'h00011, 18'h3FFFF, 8'd1, 1'b1, 1'b0, 1'b0);
    fill(20'h00010, 18'h00B02, 8'd2, 1'b1, 1'b1, 1'b0);
    fill(20'hFFFFF, 18'h12345, 8'd1, 1'b1, 1'b1, 1'b1);
    fill(20'h00020, 18'h00005, 8'd1, 1'b0, 1'b1, 1'b0);

    // Table walk: R1 R2 R4 R5
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][73:42], VEC[i][41], VEC[i][40], VEC[i][39:32], 1'b1);
      chk($sformatf("R2 hit vec %0d", i), r_hit, VEC[i][31]);
      chk($sformatf("R4/R5 fault vec %0d", i), r_fault, VEC[i][30]);
      chk($sformatf("R1 pa vec %0d", i), r_pa, VEC[i][29:0]);
    end

    // R12: idle port, write ignored
    look(32'h00010ABC, 1'b1, 1'b1, 8'd1, 1'b0);
    chk("R12 idle hit", r_hit, 0);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R12 no dirty from idle write", r_dirty, 0);
    // R6: clean write sets the modified mark
    look(32'h00010ABC, 1'b1, 1'b1, 8'd1, 1'b1);
    chk("R6 write hit no fault", r_fault, 0);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R6 dirty after write", r_dirty, 1);
    look(32'h00011000, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R6 faulting write leaves clean", r_dirty, 0);

    // R3: refill of existing page rewrites it
    fill(20'h00010, 18'h00777, 8'd1, 1'b1, 1'b1, 1'b0);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R3 rewritten pa", r_pa, 30'h00777ABC);
    chk("R3 rewrite clears dirty", r_dirty, 0);

    // R10: flush by process
    do_flush(1'b0, 8'd1);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd1, 1'b1);
    chk("R10 pid1 flushed", r_hit, 0);
    look(32'hFFFFF123, 1'b0, 1'b0, 8'd1, 1'b1);
    chk("R10 pid1 kernel page flushed", r_hit, 0);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd2, 1'b1);
    chk("R10 pid2 kept", r_hit, 1);

    // R9: flush all
    do_flush(1'b1, 8'd0);
    look(32'h00010ABC, 1'b0, 1'b1, 8'd2, 1'b1);
    chk("R9 all flushed", r_hit, 0);

    // R8: fill all 32 slots, last slot under tag 6
    for (int i = 0; i < 32; i++)
      fill(20'h00100 + 20'(i), 18'(i), (i == 31) ? 8'd6 : 8'd5, 1'b1, 1'b1, 1'b0);
    look(32'h00100000, 1'b0, 1'b1, 8'd5, 1'b1);
    fill(20'h00200, 18'h00200, 8'd5, 1'b1, 1'b1, 1'b0);
    look(32'h00101000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 lowest unused evicted", r_hit, 0);
    look(32'h00100000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 used entry kept", r_hit, 1);
    look(32'h00102000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 other entry kept", r_hit, 1);
    look(32'h00200000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 new entry present", r_hit, 1);

    // R7: hole takes priority over unused entries
    do_flush(1'b0, 8'd6);
    fill(20'h00300, 18'h00300, 8'd5, 1'b1, 1'b1, 1'b0);
    look(32'h00103000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R7 unused entry kept", r_hit, 1);
    look(32'h00300000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R7 filled into hole", r_hit, 1);

    // R8: all used -> clear and replace entry 0
    look(32'h00100000, 1'b0, 1'b1, 8'd5, 1'b1);
    look(32'h00200000, 1'b0, 1'b1, 8'd5, 1'b1);
    for (int i = 2; i < 31; i++)
      look({20'h00100 + 20'(i), 12'h000}, 1'b0, 1'b1, 8'd5, 1'b1);
    look(32'h00300000, 1'b0, 1'b1, 8'd5, 1'b1);
    fill(20'h00400, 18'h00400, 8'd5, 1'b1, 1'b1, 1'b0);
    look(32'h00400000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 all-used fill present", r_hit, 1);
    fill(20'h00500, 18'h00500, 8'd5, 1'b1, 1'b1, 1'b0);
    look(32'h00100000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 entry 0 replaced", r_hit, 0);
    look(32'h00200000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 marks cleared, entry 1 next", r_hit, 0);
    look(32'h00500000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 second fill present", r_pa, 30'h00500000);
    look(32'h00102000, 1'b0, 1'b1, 8'd5, 1'b1);
    chk("R8 entry 2 kept", r_hit, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule